// File: doc/BRIEF.md
# Taken-Only Branch Target Cache

This block keeps a small, fully associative set of branch target addresses for the fetch stage. The fetch PC is presented on the lookup port every cycle. If a valid entry's tag equals the word address of that PC, the block reports a hit and returns the cached target in the same cycle. Fetch can then steer to the predicted-taken target at once, without waiting for the branch address to be computed.

The update port carries a branch PC, its computed target and the current direction prediction. A taken prediction writes the target. It updates an existing entry in place when the PC is already cached. Otherwise it fills the lowest-numbered free entry, or the round-robin victim when every entry is valid. A not-taken prediction removes a matching entry, so the cache only ever holds targets of branches expected to be taken.

Top module: `taken_target_cache`

## Requirements
- R1: After reset no entry is valid: every lookup misses and the round-robin pointer is at entry 0.
- R2: A lookup hits in the same cycle when a valid entry's tag equals lk_pc[63:2]. lk_hit is 1 and lk_tgt carries that entry's 62-bit target. lk_pc[1:0] has no effect on the result.
- R3: On a lookup miss, lk_hit is 0 and lk_tgt is all zeros.
- R4: An update with up_taken=1 whose PC misses allocates an entry. Lookups see it from the cycle after the update.
- R5: An update with up_taken=0 whose PC hits invalidates that entry. From the next cycle, lookups of that PC miss.
- R6: An update with up_taken=0 whose PC misses changes nothing. No entry is allocated or evicted.
- R7: An update with up_taken=1 whose PC already hits replaces that entry's target in place. No second entry is allocated.
- R8: On allocation, the lowest-numbered invalid entry is used if any exists. In that case the round-robin pointer does not move.
- R9: When all entries are valid, allocation replaces the entry the round-robin pointer names. The pointer then advances by one and wraps from the last entry to entry 0.
- R10: Lookup and update can occur in the same cycle. The lookup then reflects the contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | 64 | Fetch PC to look up |
| lk_hit | output | 1 | Lookup found a valid matching entry |
| lk_tgt | output | 62 | Cached target word address (zero on miss) |
| up_valid | input | 1 | Update request this cycle |
| up_pc | input | 64 | PC of the resolved branch |
| up_tgt | input | 62 | Computed target word address |
| up_taken | input | 1 | Direction prediction: 1 taken, 0 not taken |

## Verification
Lookup and update can fall in the same cycle on the same PC. The bench provokes this in two ways: it drives a taken insert of a new PC with a lookup of that PC, and it drives a not-taken update of a cached PC with a lookup of that PC. In the same cycle the lookup must still show the old contents (a miss, and then a hit, respectively). One clock later it must show the new contents. Replacement order is judged from outside the block: after fills, in-place updates and invalidations, the bench checks which earlier PCs still hit.

// File: rtl/ttc_pkg.sv
// Shared constants and types for the taken-only branch target cache.
// Assumes 64-bit byte PCs with 4-byte aligned instructions.
package ttc_pkg;
    localparam int unsigned PC_W     = 64;
    localparam int unsigned WORD_LSB = 2;
    localparam int unsigned WADDR_W  = PC_W - WORD_LSB;

    typedef logic [WADDR_W-1:0] waddr_t;
endpackage

// File: rtl/ttc_match.sv
// Associative compare of one key against all entries.
// Produces the hit vector, the lowest hitting index and the selected target.
// Assumes at most one valid entry per tag (the update logic keeps it so);
// the target is an AND-OR select, so it is zero when nothing hits.
module ttc_match
    import ttc_pkg::*;
#(
    parameter int unsigned N     = 32,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  waddr_t           key,
    input  logic [N-1:0]     vld,
    input  waddr_t           tags [N],
    input  waddr_t           tgts [N],
    output logic [N-1:0]     hits,
    output logic             any_hit,
    output logic [IDX_W-1:0] hit_idx,
    output waddr_t           hit_tgt
);
    // one comparator per entry
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hits[g] = vld[g] && (tags[g] == key);
    end

    assign any_hit = |hits;

    // encode the hitting index and OR together the selected target
    always_comb begin
        hit_idx = '0;
        hit_tgt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) hit_idx = IDX_W'(i);
            hit_tgt = hit_tgt | (tgts[i] & {WADDR_W{hits[i]}});
        end
    end
endmodule

// File: rtl/ttc_victim.sv
// Chooses the entry to fill on an allocating insert.
// The lowest invalid entry comes first. When every entry is valid,
// the round-robin pointer is used, and it advances only on that replacement.
module ttc_victim #(
    parameter int unsigned N     = 32,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     vld,
    input  logic             alloc,
    output logic [IDX_W-1:0] slot,
    output logic             full
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;

    assign full = &vld;

    // find the lowest-numbered invalid entry
    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) free_idx = IDX_W'(i);
        end
    end

    assign slot = full ? rr_q : free_idx;

    // advance the round-robin pointer on a real replacement only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (alloc && full) begin
            rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    // R9
    rr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && full) |=> (32'(rr_q) == (32'($past(rr_q)) + 1) % N));

    // R8
    rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc && full) |=> $stable(rr_q));

    // R8
    free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && !full) |-> !vld[slot]);
endmodule

// File: rtl/taken_target_cache.sv
// Fully associative cache of predicted-taken branch targets.
// Lookup is combinational on the current contents. Updates take effect
// at the clock edge: a taken update inserts or rewrites, and a not-taken
// update deletes a matching entry. Tags are PC[63:2].
module taken_target_cache
    import ttc_pkg::*;
#(
    parameter int unsigned ENTRIES = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PC_W-1:0]    lk_pc,
    output logic               lk_hit,
    output logic [WADDR_W-1:0] lk_tgt,
    input  logic               up_valid,
    input  logic [PC_W-1:0]    up_pc,
    input  logic [WADDR_W-1:0] up_tgt,
    input  logic               up_taken
);
    localparam int unsigned IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] valid_q;
    waddr_t             tag_q [ENTRIES];
    waddr_t             tgt_q [ENTRIES];

    waddr_t             lk_key, up_key;
    logic [ENTRIES-1:0] lk_hits, up_hits;
    logic [IDX_W-1:0]   lk_idx, up_idx, slot;
    waddr_t             up_cur_tgt;
    logic               up_any, alloc, full;

    assign lk_key = lk_pc[PC_W-1:WORD_LSB];
    assign up_key = up_pc[PC_W-1:WORD_LSB];
    assign alloc  = up_valid && up_taken && !up_any;

    // lookup port compare
    ttc_match #(.N(ENTRIES), .IDX_W(IDX_W)) lk_match_i (
        .key(lk_key), .vld(valid_q), .tags(tag_q), .tgts(tgt_q),
        .hits(lk_hits), .any_hit(lk_hit), .hit_idx(lk_idx), .hit_tgt(lk_tgt)
    );

    // update port compare
    ttc_match #(.N(ENTRIES), .IDX_W(IDX_W)) up_match_i (
        .key(up_key), .vld(valid_q), .tags(tag_q), .tgts(tgt_q),
        .hits(up_hits), .any_hit(up_any), .hit_idx(up_idx), .hit_tgt(up_cur_tgt)
    );

    // slot choice for allocating inserts
    ttc_victim #(.N(ENTRIES), .IDX_W(IDX_W)) victim_i (
        .clk(clk), .rst_n(rst_n), .vld(valid_q), .alloc(alloc),
        .slot(slot), .full(full)
    );

    // valid bits: set on allocation, cleared on not-taken hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (up_valid) begin
            if (alloc) valid_q[slot] <= 1'b1;
            else if (!up_taken && up_any) valid_q[up_idx] <= 1'b0;
        end
    end

    // tag and target storage: write on insert or in-place rewrite
    always_ff @(posedge clk) begin
        if (up_valid && up_taken) begin
            if (up_any) begin
                tgt_q[up_idx] <= up_tgt;
            end else begin
                tag_q[slot] <= up_key;
                tgt_q[slot] <= up_tgt;
            end
        end
    end

    // R2
    lk_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hits));

    // R7
    up_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(up_hits));

    // R4
    insert_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> (valid_q[$past(slot)] && tag_q[$past(slot)] == $past(up_key)
                   && tgt_q[$past(slot)] == $past(up_tgt)));

    // R5
    delete_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && up_any) |=> !valid_q[$past(up_idx)]);

    // R6
    delete_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && !up_any) |=> $stable(valid_q));

    // R7
    rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && up_any) |=>
            ($stable(valid_q) && tgt_q[$past(up_idx)] == $past(up_tgt)));

    // R3
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_tgt == '0));
endmodule

// File: tb/taken_target_cache_tb_top.sv
// Directed bench for the taken-only branch target cache.
module taken_target_cache_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] lk_pc = '0;
    logic        lk_hit;
    logic [61:0] lk_tgt;
    logic        up_valid = 1'b0;
    logic [63:0] up_pc = '0;
    logic [61:0] up_tgt = '0;
    logic        up_taken = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    taken_target_cache #(.ENTRIES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_tgt(lk_tgt),
        .up_valid(up_valid), .up_pc(up_pc), .up_tgt(up_tgt), .up_taken(up_taken)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [63:0] mkpc(int i);
        return 64'h0000_4000_0000_0000 + 64'(i) * 64'h0001_0010;
    endfunction

    function automatic logic [61:0] mktgt(int i);
        return 62'h0000_0000_0123_4000 + 62'(i) * 62'h77;
    endfunction

    task automatic apply_reset();
        rst_n = 1'b0;
        up_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // look up pc and compare against expectation (no clock edge involved)
    task automatic check_lk(logic [63:0] pc, bit exp_hit, logic [61:0] exp_tgt, string req);
        logic [61:0] want;
        want = exp_hit ? exp_tgt : '0;
        lk_pc = pc;
        #1;
        checks++;
        if (lk_hit !== exp_hit || lk_tgt !== want) begin
            fails++;
            $display("FAIL %s pc=%h hit=%0b tgt=%h expected hit=%0b tgt=%h",
                     req, pc, lk_hit, lk_tgt, exp_hit, want);
        end
    endtask

    // one-cycle update, starting and ending at a falling edge
    task automatic do_update(logic [63:0] pc, logic [61:0] tgt, bit taken);
        up_valid = 1'b1;
        up_pc    = pc;
        up_tgt   = tgt;
        up_taken = taken;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic t_reset();
        apply_reset();
        check_lk(mkpc(0), 0, '0, "R1");
        check_lk(64'h0, 0, '0, "R1");
        check_lk(mkpc(7), 0, '0, "R3");
    endtask

    task automatic t_basic();
        apply_reset();
        do_update(mkpc(1), mktgt(1), 1);
        do_update(mkpc(2), mktgt(2), 1);
        check_lk(mkpc(1), 1, mktgt(1), "R4");
        check_lk(mkpc(2), 1, mktgt(2), "R2");
        check_lk(mkpc(1) | 64'h3, 1, mktgt(1), "R2");
        check_lk(mkpc(1) + 64'h4, 0, '0, "R3");
    endtask

    task automatic t_delete();
        apply_reset();
        do_update(mkpc(1), mktgt(1), 1);
        do_update(mkpc(2), mktgt(2), 1);
        do_update(mkpc(9), mktgt(9), 0);
        check_lk(mkpc(9), 0, '0, "R6");
        check_lk(mkpc(1), 1, mktgt(1), "R6");
        check_lk(mkpc(2), 1, mktgt(2), "R6");
        do_update(mkpc(1), mktgt(1), 0);
        check_lk(mkpc(1), 0, '0, "R5");
        check_lk(mkpc(2), 1, mktgt(2), "R5");
    endtask

    task automatic t_same_cycle();
        apply_reset();
        // taken insert with lookup of the same PC
        up_valid = 1'b1; up_pc = mkpc(3); up_tgt = mktgt(3); up_taken = 1'b1;
        check_lk(mkpc(3), 0, '0, "R10");
        @(negedge clk);
        up_valid = 1'b0;
        check_lk(mkpc(3), 1, mktgt(3), "R10");
        // not-taken delete with lookup of the same PC
        up_valid = 1'b1; up_pc = mkpc(3); up_tgt = mktgt(3); up_taken = 1'b0;
        check_lk(mkpc(3), 1, mktgt(3), "R10");
        @(negedge clk);
        up_valid = 1'b0;
        check_lk(mkpc(3), 0, '0, "R10");
    endtask

    task automatic t_inplace();
        apply_reset();
        for (int i = 0; i < N - 1; i++) do_update(mkpc(i), mktgt(i), 1);
        do_update(mkpc(3), mktgt(500), 1);
        check_lk(mkpc(3), 1, mktgt(500), "R7");
        do_update(mkpc(N - 1), mktgt(N - 1), 1);   // fills the last free entry
        do_update(mkpc(200), mktgt(200), 1);       // first replacement: entry 0
        check_lk(mkpc(0), 0, '0, "R7");
        check_lk(mkpc(1), 1, mktgt(1), "R7");
        check_lk(mkpc(3), 1, mktgt(500), "R7");
        check_lk(mkpc(N - 1), 1, mktgt(N - 1), "R7");
    endtask

    task automatic t_round_robin();
        int miss;
        apply_reset();
        for (int i = 0; i < N; i++) do_update(mkpc(i), mktgt(i), 1);
        miss = 0;
        for (int i = 0; i < N; i++) begin
            lk_pc = mkpc(i);
            #1;
            if (!lk_hit || lk_tgt !== mktgt(i)) miss++;
        end
        checks++;
        if (miss != 0) begin
            fails++;
            $display("FAIL R8 fill misses=%0d expected 0", miss);
        end
        do_update(mkpc(300), mktgt(300), 1);   // pointer 0 -> evicts entry 0
        check_lk(mkpc(0), 0, '0, "R9");
        check_lk(mkpc(1), 1, mktgt(1), "R9");
        check_lk(mkpc(300), 1, mktgt(300), "R9");
        do_update(mkpc(301), mktgt(301), 1);   // evicts entry 1
        check_lk(mkpc(1), 0, '0, "R9");
        do_update(mkpc(5), mktgt(5), 0);       // frees entry 5
        do_update(mkpc(302), mktgt(302), 1);   // fills entry 5, pointer stays 2
        check_lk(mkpc(302), 1, mktgt(302), "R8");
        check_lk(mkpc(2), 1, mktgt(2), "R8");
        do_update(mkpc(303), mktgt(303), 1);   // evicts entry 2
        check_lk(mkpc(2), 0, '0, "R8");
        check_lk(mkpc(3), 1, mktgt(3), "R9");
        for (int k = 0; k < N - 3; k++) do_update(mkpc(400 + k), mktgt(400 + k), 1);
        do_update(mkpc(600), mktgt(600), 1);   // pointer wrapped: evicts entry 0
        check_lk(mkpc(300), 0, '0, "R9");
        check_lk(mkpc(301), 1, mktgt(301), "R9");
        check_lk(mkpc(600), 1, mktgt(600), "R9");
        check_lk(mkpc(400 + N - 4), 1, mktgt(400 + N - 4), "R9");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_delete();
        t_same_cycle();
        t_inplace();
        t_round_robin();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule